// File: doc/BRIEF.md
# Modular Multiplier for the Prime 2^255 - 19

This block multiplies two 255-bit operands and returns their product reduced modulo p = 2^255 - 19, fully reduced into the range 0 to p-1. Each operand is cut into fifteen unsigned 17-bit limbs. Fifteen limb multipliers each own one output column. In each of fifteen cycles, every multiplier forms one 17x17 product and adds it into its column. Because 2^255 is congruent to 19 modulo p, a product that belongs above bit 254 lands in a separate "wrapped" accumulator of the same column. That accumulator is weighted by 19 when the column is handed on.

A second stage receives the fifteen column sums. It folds the wrapped half in with the factor 19 and ripples the carries limb by limb. It feeds the top carry back in with weight 19 and subtracts p once if the value is still at or above p. The two stages form a pipeline. A new operand pair may be accepted as soon as the first stage has handed its columns on. Back-to-back products therefore leave the block every 17 cycles.

A host presents operands and pulses start while ready is high. Later it takes the result on the single-cycle done pulse.

Top module: `modmul_p25519`

## Requirements
- R1: During and right after reset, ready is 1, done is 0 and y is 0.
- R2: Operands a and b are captured on a rising edge where start and ready are both 1. ready is 0 in the cycle that follows that edge.
- R3: A start pulse presented while ready is 0 is ignored. It produces no result and does not alter the results of operations already accepted.
- R4: For any 255-bit a and b, including 0, p-1 and 2^255-1, the result y equals (a*b) mod p with p = 2^255 - 19.
- R5: Whenever done is 1, y is below p.
- R6: done is high for exactly one cycle per accepted operation.
- R7: Count the capture edge as edge 1. done and the matching y appear right after edge 34.
- R8: ready returns to 1 after edge 17, counting the capture edge as edge 1. A host that restarts at once receives results exactly 17 cycles apart.
- R9: y holds its value in every cycle in which done is 0.

Results are delivered in the order the operations were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to capture a and b; honoured only while ready is 1 |
| a | input | 255 | First operand, limb 0 in bits 16:0 |
| b | input | 255 | Second operand, limb 0 in bits 16:0 |
| ready | output | 1 | High when the first stage can take a new operand pair |
| done | output | 1 | One-cycle pulse marking a valid result on y |
| y | output | 255 | Reduced product, held between done pulses |

## Verification
A rotation slip between the limb schedule and the wrap flags puts a product into the wrong column or gives it the wrong weight. That shows up as a wrong y on the first result whose operands have non-zero limbs in the affected positions. Operands such as p-1, 2^255-1 and single set limbs therefore expose it within one operation. A lost carry in the ripple stage or a missing final subtraction shows only for products whose columns overflow or land in [p, 2^255). The all-ones operands reach those cases. A stage handover that is off by a cycle shows at once as a shifted done, a wrong ready gap, or a corrupted second result in a back-to-back burst.

// File: rtl/modmul_pkg.sv
package modmul_pkg;
  // limb geometry and the fold constant c of p = 2^(LIMB_W*NLIMB) - c
  localparam int LIMB_W = 17;
  localparam int NLIMB  = 15;
  localparam int FOLD   = 19;
endpackage

// File: rtl/modmul_col_mac.sv
// One column multiplier: one limb product per cycle, summed into either the
// in-range or the wrapped accumulator of its column.
module modmul_col_mac #(
  parameter int LW = 17,
  parameter int AW = 38
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          en,
  input  logic          wrap,
  input  logic [LW-1:0] x,
  input  logic [LW-1:0] m,
  output logic [AW-1:0] lo,
  output logic [AW-1:0] hi
);
  logic [2*LW-1:0] prod;
  logic [AW-1:0]   prod_x;

  always_comb begin
    prod   = x * m;
    prod_x = AW'(prod);
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      lo <= '0;
      hi <= '0;
    end else if (en) begin
      if (wrap) hi <= hi + prod_x;
      else      lo <= lo + prod_x;
    end
  end
endmodule

// File: rtl/modmul_reduce.sv
// Second stage: weight wrapped sums by FOLD, ripple carries one limb per
// cycle, feed the top carry back, then one conditional subtraction of p.
module modmul_reduce #(
  parameter int LW    = 17,
  parameter int NLIMB = 15,
  parameter int FOLD  = 19,
  parameter int AW    = 38,
  localparam int FW    = LW * NLIMB,
  localparam int CW    = AW + $clog2(FOLD + 1) + 1,
  localparam int CNT_W = $clog2(NLIMB)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic [NLIMB-1:0][AW-1:0]   lo,
  input  logic [NLIMB-1:0][AW-1:0]   hi,
  output logic [FW-1:0]              y,
  output logic                       done
);
  localparam logic [FW-1:0] P = {FW{1'b1}} - FW'(FOLD - 1);

  logic [NLIMB-1:0][CW-1:0] col_in, col;
  logic [NLIMB-1:0][LW-1:0] limbs;
  logic [CW-1:0]            carry, t;
  logic [CNT_W-1:0]         idx;
  logic                     pact, fold_v, sub_v;
  logic [FW:0]              w;
  logic [FW-1:0]            w1, v;

  for (genvar k = 0; k < NLIMB; k++) begin : g_col
    assign col_in[k] = CW'(lo[k]) + CW'(hi[k]) * CW'(FOLD);
  end

  always_comb begin
    t  = col[idx] + carry;
    w  = {1'b0, limbs} + (FW+1)'(carry) * (FW+1)'(FOLD);
    w1 = w[FW] ? (w[FW-1:0] + FW'(FOLD)) : w[FW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col    <= '0;
      limbs  <= '0;
      carry  <= '0;
      idx    <= '0;
      pact   <= 1'b0;
      fold_v <= 1'b0;
      sub_v  <= 1'b0;
      v      <= '0;
      y      <= '0;
      done   <= 1'b0;
    end else begin
      fold_v <= 1'b0;
      sub_v  <= fold_v;
      done   <= sub_v;
      if (load) begin
        col   <= col_in;
        carry <= '0;
        idx   <= '0;
        pact  <= 1'b1;
      end else if (pact) begin
        limbs[idx] <= t[LW-1:0];
        carry      <= t >> LW;
        idx        <= idx + 1'b1;
        if (idx == CNT_W'(NLIMB - 1)) begin
          pact   <= 1'b0;
          fold_v <= 1'b1;
        end
      end
      if (fold_v) v <= w1;
      if (sub_v)  y <= (v >= P) ? (v - P) : v;
    end
  end
endmodule

// File: rtl/modmul_p25519.sv
module modmul_p25519 #(
  parameter int LIMB_W = modmul_pkg::LIMB_W,
  parameter int NLIMB  = modmul_pkg::NLIMB,
  parameter int FOLD   = modmul_pkg::FOLD,
  localparam int FW    = LIMB_W * NLIMB,
  localparam int AW    = 2 * LIMB_W + $clog2(NLIMB + 1),
  localparam int CNT_W = $clog2(NLIMB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [FW-1:0] a,
  input  logic [FW-1:0] b,
  output logic          ready,
  output logic          done,
  output logic [FW-1:0] y
);
  logic [NLIMB-1:0][LIMB_W-1:0] a_sh, b_rot;
  logic [NLIMB-1:0][AW-1:0]     acc_lo, acc_hi;
  logic [CNT_W-1:0]             cnt;
  logic                         run, hand, accept;

  assign accept = start && ready;

  // stage 1: a shifts down one limb per cycle, b rotates up, so column k
  // sees a[t]*b[(k-t) mod NLIMB]; the wrapped terms have t > k
  always_ff @(posedge clk) begin
    if (rst) begin
      a_sh  <= '0;
      b_rot <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      hand  <= 1'b0;
      ready <= 1'b1;
    end else begin
      hand <= 1'b0;
      if (accept) begin
        a_sh  <= a;
        b_rot <= b;
        cnt   <= '0;
        run   <= 1'b1;
        ready <= 1'b0;
      end else if (run) begin
        a_sh  <= {{LIMB_W{1'b0}}, a_sh[NLIMB-1:1]};
        b_rot <= {b_rot[NLIMB-2:0], b_rot[NLIMB-1]};
        cnt   <= cnt + 1'b1;
        if (cnt == CNT_W'(NLIMB - 1)) begin
          run  <= 1'b0;
          hand <= 1'b1;
        end
      end else if (hand) begin
        ready <= 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NLIMB; k++) begin : g_mac
    modmul_col_mac #(.LW(LIMB_W), .AW(AW)) u_mac (
      .clk  (clk),
      .clr  (rst || accept),
      .en   (run),
      .wrap (cnt > CNT_W'(k)),
      .x    (a_sh[0]),
      .m    (b_rot[k]),
      .lo   (acc_lo[k]),
      .hi   (acc_hi[k])
    );
  end

  modmul_reduce #(.LW(LIMB_W), .NLIMB(NLIMB), .FOLD(FOLD), .AW(AW)) u_red (
    .clk  (clk),
    .rst  (rst),
    .load (hand),
    .lo   (acc_lo),
    .hi   (acc_hi),
    .y    (y),
    .done (done)
  );
endmodule

// File: rtl/modmul_p25519_chk.sv
module modmul_p25519_chk #(
  parameter int FW   = 255,
  parameter int FOLD = 19
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          ready,
  input logic          done,
  input logic [FW-1:0] y
);
  localparam logic [FW-1:0] P = {FW{1'b1}} - FW'(FOLD - 1);

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (start && ready) |=> !ready);

  // R5
  result_reduced_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (y < P));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(y));
endmodule

bind modmul_p25519 modmul_p25519_chk #(.FW(FW), .FOLD(FOLD)) u_chk (
  .clk(clk), .rst(rst), .start(start), .ready(ready), .done(done), .y(y)
);

// File: tb/modmul_p25519_tb.sv
module modmul_p25519_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 255;
  localparam logic [FW-1:0] P = {FW{1'b1}} - FW'(18);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [FW-1:0] a = '0, b = '0;
  logic          ready, done;
  logic [FW-1:0] y;

  int nchk = 0, nerr = 0, cyc = 0, ndone = 0, nissue = 0;
  logic [FW-1:0] exp_q[$];
  int            iss_q[$];
  int            done_t[$];
  bit            prev_done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  modmul_p25519 u_dut (.clk(clk), .rst(rst), .start(start), .a(a), .b(b),
                       .ready(ready), .done(done), .y(y));

  function automatic logic [FW-1:0] model(input logic [FW-1:0] x, input logic [FW-1:0] z);
    logic [2*FW-1:0] m;
    m = {{FW{1'b0}}, x} * {{FW{1'b0}}, z};
    return FW'(m % {{FW{1'b0}}, P});
  endfunction

  function automatic logic [FW-1:0] rnd255();
    logic [FW-1:0] r = '0;
    for (int i = 0; i < 8; i++) r = {r[FW-33:0], 32'($urandom)};
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: waits for ready, presents one operand pair, queues the expectation
  task automatic issue(input logic [FW-1:0] x, input logic [FW-1:0] z);
    while (!ready) @(negedge clk);
    a = x; b = z; start = 1'b1;
    exp_q.push_back(model(x, z));
    iss_q.push_back(cyc);
    nissue++;
    @(negedge clk);
    start = 1'b0;
    chk(ready == 1'b0, "R2 ready low after accept", FW'(ready), '0);
  endtask

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_done && done) chk(1'b0, "R6 done longer than one cycle", FW'(1), '0);
      if (done) begin
        ndone++;
        done_t.push_back(cyc);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 result without accepted start", y, '0);
        end else begin
          logic [FW-1:0] e;
          int            t0;
          e  = exp_q.pop_front();
          t0 = iss_q.pop_front();
          chk(y == e, "R4 product mod p", y, e);
          chk(y < P, "R5 result below p", y, P);
          chk(cyc - t0 == 34, "R7 latency", FW'(cyc - t0), FW'(34));
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", FW'(cyc), '0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int t0, n0;
    repeat (3) @(negedge clk);
    // R1
    chk(ready == 1'b1, "R1 ready in reset", FW'(ready), FW'(1));
    chk(done == 1'b0, "R1 done in reset", FW'(done), '0);
    chk(y == '0, "R1 y in reset", y, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1 && done == 1'b0 && y == '0, "R1 state after reset", y, '0);

    // R4 corner operands
    issue('0, P - 1);
    issue(P - 1, P - 1);
    issue(P - 1, FW'(2));
    issue({FW{1'b1}}, {FW{1'b1}});
    issue(FW'(1), P - 1);
    issue(FW'(1) << 254, FW'(2));
    issue(FW'(17'h1FFFF) << 238, {FW{1'b1}});
    issue(FW'(17'h1FFFF), FW'(17'h1FFFF) << 238);
    drain();

    // R8 ready gap measured from the capture edge
    a = rnd255(); b = rnd255();
    start = 1'b1;
    exp_q.push_back(model(a, b)); iss_q.push_back(cyc); nissue++;
    t0 = cyc;
    @(negedge clk);
    start = 1'b0;
    while (!ready) @(negedge clk);
    chk(cyc - t0 == 17, "R8 ready returns after 17 edges", FW'(cyc - t0), FW'(17));
    drain();

    // R8 back-to-back burst spacing
    n0 = done_t.size();
    for (int i = 0; i < 4; i++) issue(rnd255(), rnd255());
    drain();
    for (int i = n0 + 1; i < done_t.size(); i++)
      chk(done_t[i] - done_t[i-1] == 17, "R8 back-to-back spacing",
          FW'(done_t[i] - done_t[i-1]), FW'(17));

    // R3 starts while busy are ignored
    issue(P - 2, P - 3);
    repeat (2) @(negedge clk);
    a = {FW{1'b1}}; b = FW'(5); start = 1'b1;
    repeat (8) @(negedge clk);
    start = 1'b0;
    drain();
    repeat (40) @(negedge clk);
    chk(ndone == nissue, "R3 no extra results", FW'(ndone), FW'(nissue));

    // R4 random operands
    for (int i = 0; i < 8; i++) issue(rnd255(), rnd255());
    drain();
    chk(ndone == nissue, "R6 one done per operation", FW'(ndone), FW'(nissue));

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule